// File: doc/BRIEF.md
# Six-Input Vote Tally Unit

The block counts how many of six single-bit vote lines are asserted and presents that count as a 3-bit binary number. It has no clock and no state. The output follows the inputs after the propagation delay of the logic. It suits any place where a small set of flags has to be turned into a count within a single cycle.

The count is formed in two stages. In the first stage the votes are split into two triples. Each triple goes into one full-adder cell. Because a full adder adds three bits, its carry and sum together form a 2-bit count of that triple. In the second stage a 4-bit ripple-carry adder, built as a chain of full-adder cells, adds the two partial counts. Its low three sum bits are the tally.

A parameter selects the gate form of the full-adder cell. One form is two half adders with an OR. The other is a majority sum-of-products. Both forms give identical results.

Top module: `vote_tally`

## Requirements
- R1: For every one of the 64 combinations on `votes_i`, `tally_o` equals the number of bits of `votes_i` that are 1, as an unsigned binary value.
- R2: Bits 2..0 of `votes_i` are reduced by one full-adder cell and bits 5..3 by another. Each cell produces a 2-bit partial count, with the carry as bit 1 and the sum as bit 0, equal to the number of ones in its triple. As a result, asserting only votes from one triple gives a tally of 0 to 3.
- R3: The two partial counts are added in a 4-bit ripple-carry adder. The adder's carry-in is 0, and its two upper operand bits are 0 on both operands. With all votes clear, the tally is therefore 0 (binary 000).
- R4: The adder's carry-out and its sum bit 3 never become 1. With all six votes set, the tally is 6 (binary 110).
- R5: Every full-adder cell computes sum = x xor y xor cin and carry = x·y + (x xor y)·cin. Tallies of 1, 2 and 3 taken from a single triple, and tallies of 4 and 5 taken across both triples, all match the count.
- R6: The block is purely combinational. A change on `votes_i` appears on `tally_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| votes_i | input | 6 | Vote lines; a 1 means the vote is cast |
| tally_o | output | 3 | Number of vote lines at 1 |

## Verification
The in-RTL checks take for granted that `votes_i` carries only 0 and 1 on every bit. They also take for granted that they are read once the combinational logic has settled for the current input. The bench drives known two-state values only. It changes inputs away from the sampling point and waits before it reads the tally. Random patterns drawn from a fixed seed are masked to six bits. The bench also sweeps all 64 patterns, so no value outside the input space is ever applied.

// File: rtl/vote_tally_pkg.sv
package vote_tally_pkg;

   // Votes handled by one full-adder cell.
   localparam int unsigned TRIPLE_W = 3;

   // Width of one partial count from a full-adder cell.
   localparam int unsigned PART_W = 2;

   // Gate forms of the full-adder cell.
   typedef enum logic [0:0] {
      FA_HALF_PAIR = 1'b0,
      FA_MAJORITY  = 1'b1
   } fa_form_e;

   // Bits needed to hold a count from 0 to n.
   function automatic int unsigned count_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/vt_fa_cell.sv
module vt_fa_cell
   import vote_tally_pkg::*;
#(
   parameter fa_form_e FORM = FA_HALF_PAIR
) (
   input  logic x_i,
   input  logic y_i,
   input  logic ci_i,
   output logic s_o,
   output logic co_o
);

   generate
      if (FORM == FA_HALF_PAIR) begin : g_half_pair
         logic p_w;
         logic g_w;
         always_comb begin
            p_w  = x_i ^ y_i;
            g_w  = x_i & y_i;
            s_o  = p_w ^ ci_i;
            co_o = g_w | (p_w & ci_i);
         end
      end else begin : g_majority
         always_comb begin
            s_o  = (~x_i & ~y_i &  ci_i) | (~x_i &  y_i & ~ci_i) |
                   ( x_i & ~y_i & ~ci_i) | ( x_i &  y_i &  ci_i);
            co_o = (x_i & y_i) | (x_i & ci_i) | (y_i & ci_i);
         end
      end
   endgenerate

   // Arithmetic view of the cell, independent of the gate form chosen.
   always_comb begin
      AST_FA_ARITH: assert ({co_o, s_o} == 2'(x_i) + 2'(y_i) + 2'(ci_i))
         else $error("full-adder cell output mismatch"); // R5
   end

endmodule

// File: rtl/vt_triad_reduce.sv
module vt_triad_reduce
   import vote_tally_pkg::*;
#(
   parameter fa_form_e FORM = FA_HALF_PAIR
) (
   input  logic [TRIPLE_W-1:0] bits_i,
   output logic [PART_W-1:0]   cnt_o
);

   logic s_w;
   logic c_w;

   vt_fa_cell #(.FORM(FORM)) u_cell (
      .x_i  (bits_i[0]),
      .y_i  (bits_i[1]),
      .ci_i (bits_i[2]),
      .s_o  (s_w),
      .co_o (c_w)
   );

   always_comb cnt_o = {c_w, s_w};

   always_comb begin
      AST_TRIAD_COUNT: assert (32'(cnt_o) == $countones(bits_i))
         else $error("triple count mismatch"); // R2
   end

endmodule

// File: rtl/vt_ripple_adder.sv
module vt_ripple_adder
   import vote_tally_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter fa_form_e    FORM  = FA_HALF_PAIR
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             ci_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             co_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("vt_ripple_adder: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH:0] carry_w;

   always_comb carry_w[0] = ci_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      vt_fa_cell #(.FORM(FORM)) u_fa (
         .x_i  (a_i[i]),
         .y_i  (b_i[i]),
         .ci_i (carry_w[i]),
         .s_o  (sum_o[i]),
         .co_o (carry_w[i+1])
      );
   end

   always_comb co_o = carry_w[WIDTH];

   always_comb begin
      AST_ADDER_SUM: assert ({co_o, sum_o} == (WIDTH+1)'(a_i) + (WIDTH+1)'(b_i) + (WIDTH+1)'(ci_i))
         else $error("ripple adder result mismatch"); // R3
   end

endmodule

// File: rtl/vote_tally.sv
module vote_tally
   import vote_tally_pkg::*;
#(
   parameter int unsigned N_VOTES = 6,
   parameter int unsigned ADD_W   = 4,
   parameter fa_form_e    FORM    = FA_HALF_PAIR,
   localparam int unsigned N_GRP   = N_VOTES / TRIPLE_W,
   localparam int unsigned TALLY_W = count_width(N_VOTES)
) (
   input  logic [N_VOTES-1:0] votes_i,
   output logic [TALLY_W-1:0] tally_o
);

   generate
      if (N_VOTES != 6) begin : g_bad_votes
         $error("vote_tally: the two-stage structure needs exactly six votes");
      end
      if (ADD_W < TALLY_W) begin : g_bad_add
         $error("vote_tally: adder narrower than the tally");
      end
   endgenerate

   logic [PART_W-1:0] part_w [N_GRP];
   logic [ADD_W-1:0]  op_a_w;
   logic [ADD_W-1:0]  op_b_w;
   logic [ADD_W-1:0]  sum_w;
   logic              cout_w;

   for (genvar g = 0; g < N_GRP; g++) begin : g_triad
      vt_triad_reduce #(.FORM(FORM)) u_triad (
         .bits_i (votes_i[g*TRIPLE_W +: TRIPLE_W]),
         .cnt_o  (part_w[g])
      );
   end

   // Partial counts are zero-extended into the adder operands.
   always_comb begin
      op_a_w = '0;
      op_b_w = '0;
      op_a_w[PART_W-1:0] = part_w[0];
      op_b_w[PART_W-1:0] = part_w[1];
   end

   vt_ripple_adder #(.WIDTH(ADD_W), .FORM(FORM)) u_adder (
      .a_i   (op_a_w),
      .b_i   (op_b_w),
      .ci_i  (1'b0),
      .sum_o (sum_w),
      .co_o  (cout_w)
   );

   always_comb tally_o = sum_w[TALLY_W-1:0];

   always_comb begin
      AST_TALLY_COUNT: assert (32'(tally_o) == $countones(votes_i))
         else $error("tally differs from vote count"); // R1
      AST_HIGH_BITS_ZERO: assert (!cout_w && (sum_w[ADD_W-1:TALLY_W] == '0))
         else $error("unused adder bits became set"); // R4
   end

endmodule

// File: tb/tb_vote_tally.sv
`timescale 1ns/1ps
module tb_vote_tally;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [5:0] votes;
   logic [2:0] tally;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   vote_tally dut (
      .votes_i (votes),
      .tally_o (tally)
   );

   function automatic logic [2:0] ones_of(input logic [5:0] v);
      logic [2:0] c;
      c = '0;
      for (int i = 0; i < 6; i++) c = c + 3'(v[i]);
      return c;
   endfunction

   task automatic apply_check(input logic [5:0] v, input string req);
      @(negedge clk);
      votes = v;
      #1;
      n_chk++;
      if (tally !== ones_of(v)) begin
         n_bad++;
         $display("FAIL %s votes=%b actual=%0d expected=%0d", req, v, tally, ones_of(v));
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] r;
      votes = '0;
      // Idle state: nothing asserted gives zero
      apply_check(6'b000000, "R3");
      // Single-triple counts, low and high triple
      apply_check(6'b000001, "R2");
      apply_check(6'b000011, "R2");
      apply_check(6'b000111, "R2");
      apply_check(6'b111000, "R2");
      apply_check(6'b010000, "R5");
      apply_check(6'b101000, "R5");
      // Cross-triple counts 4 and 5
      apply_check(6'b011011, "R5");
      apply_check(6'b110111, "R5");
      // All set: maximum
      apply_check(6'b111111, "R4");
      // Combinational response: change without waiting a full edge
      votes = 6'b000000;
      #0.5 votes = 6'b100101;
      #0.5;
      n_chk++;
      if (tally !== 3'd3) begin
         n_bad++;
         $display("FAIL R6 actual=%0d expected=3", tally);
      end
      // Exhaustive sweep
      for (int v = 0; v < 64; v++) apply_check(6'(v), "R1");
      // Seeded random patterns
      r = $urandom(32'd2718);
      for (int k = 0; k < 200; k++) begin
         r = $urandom;
         apply_check(r[5:0], "R1");
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule